// File: doc/BRIEF.md
# PLL Charge-Pump Holdover Controller

This controller decides when a PLL charge pump is forced into high impedance so that the oscillator keeps its last tuning voltage, and when it is let go again. Holdover can be entered by hand through an active-low sync input, or automatically when the digital lock flag drops. In both cases the pump is released only in step with a reference strobe at the phase detector. On that same strobe the controller sends a one-cycle reset to the feedback B counter, which brings the divider edges back into line.

In automatic mode, loss of lock is believed only if the analog lock pin is high when the lock flag falls. A configuration bit can turn that check off. After an automatic release the controller stays disarmed until lock has been regained. While holdover is enabled, any calibration request is reported as blocked.

All of this takes effect only when both the master enable bit and the function enable bit are set. The sync input and the analog lock pin are resynchronised with a `SYNC_STAGES`-deep flop chain (default 2). The lock flag and the reference strobe are taken to be synchronous to `clk_i`.

Top module: `cp_holdover_ctrl`

## Requirements
- R1: While and after reset, `cp_hiz_o` and `bcnt_rst_o` are 0, and the controller starts in the idle state.
- R2: If `master_en_i` or `func_en_i` is 0, neither a sync fall nor a lock fall raises `cp_hiz_o`.
- R3: In manual mode, a falling edge on `sync_ni` raises `cp_hiz_o` on the third rising clock edge after the fall (two synchroniser stages, then the state register). Entry is edge-triggered: keeping `sync_ni` low after a release does not re-enter.
- R4: After a manual entry, reference strobes are ignored while the synchronised `sync_ni` is low. The first strobe sampled once the synchronised `sync_ni` is high releases the pump, and `cp_hiz_o` is 0 after that clock edge.
- R5: `bcnt_rst_o` is high for exactly the one cycle in which `cp_hiz_o` first reads 0 after a release by strobe. It stays 0 at every other time.
- R6: In automatic mode, a 1-to-0 change of `lock_det_i` while the synchronised analog lock pin is high raises `cp_hiz_o` on the next clock edge.
- R7: When `ald_check_en_i` is 1, a lock fall with the synchronised analog lock pin low does not enter holdover. When `ald_check_en_i` is 0, the pin level is ignored and treated as high.
- R8: An automatic holdover is released by the next strobe on `ref_edge_i`, with `cp_hiz_o` 0 after that edge.
- R9: After an automatic release, `cp_hiz_o` stays 0 for as long as `lock_det_i` stays low. Once `lock_det_i` has been high, a new lock fall enters holdover again.
- R10: `cal_blocked_o` equals `cal_req_i` AND `master_en_i` AND `func_en_i` in the same cycle.
- R11: If a manual entry and an automatic trigger overlap, strobes do not release the pump until the synchronised `sync_ni` is high. After that release, the controller waits for relock as in R9.
- R12: Clearing either enable bit during holdover drops `cp_hiz_o` on the next clock edge without a `bcnt_rst_o` pulse.
- R13: With `manual_en_i` at 0, sync edges have no effect. With `auto_en_i` at 0, lock falls have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Manual holdover request, active low, asynchronous |
| lock_det_i | input | 1 | Digital lock flag, synchronous |
| ald_pin_i | input | 1 | Analog lock pin level, asynchronous |
| ref_edge_i | input | 1 | One-cycle strobe per reference edge at the phase detector |
| master_en_i | input | 1 | Master holdover enable |
| func_en_i | input | 1 | Holdover function enable |
| manual_en_i | input | 1 | Enables sync-driven holdover |
| auto_en_i | input | 1 | Enables lock-driven holdover |
| ald_check_en_i | input | 1 | 1: qualify lock fall with the analog pin; 0: treat the pin as high |
| cal_req_i | input | 1 | Oscillator calibration request |
| cp_hiz_o | output | 1 | Charge pump high-impedance control |
| bcnt_rst_o | output | 1 | One-cycle reset to the feedback B counter |
| cal_blocked_o | output | 1 | Calibration request refused because holdover is enabled |

## Verification
Four input patterns are used. A sweep over all sixteen combinations of the two enables and the two mode bits separates gating faults from mode-select faults. A sync release followed by strobes one, two and three cycles later shows whether the release waits for the synchroniser, or is too early or too late by one cycle. Four combinations of the pin-check bit and the pin level separate qualified from unqualified automatic entry. An overlapping sequence, with a manual entry and then a lock fall, followed by strobes with the lock flag held low, shows whether the release waits for both conditions and whether re-arming after an automatic release is tied to a level or to an edge.

// File: rtl/hold_pkg.sv
`timescale 1ns/1ps
package hold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE         = 2'd0,
    ST_HIZ_WAIT_REF = 2'd1,
    ST_WAIT_RELOCK  = 2'd2
  } hold_state_e;
endpackage

// File: rtl/hold_sync.sv
`timescale 1ns/1ps
module hold_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= RST_VAL;
        else         chain_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= RST_VAL;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hold_trig.sv
`timescale 1ns/1ps
module hold_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_s_i,
  input  logic lock_det_i,
  input  logic ald_s_i,
  input  logic ald_check_en_i,
  input  logic man_act_i,
  input  logic auto_act_i,
  input  logic armed_i,
  output logic man_fall_o,
  output logic auto_trig_o
);
  logic sync_prev_q, lock_prev_q;
  logic lock_fall, ald_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev_q <= 1'b1;
      lock_prev_q <= 1'b0;
    end else begin
      sync_prev_q <= sync_s_i;
      lock_prev_q <= lock_det_i;
    end
  end

  assign lock_fall   = lock_prev_q & ~lock_det_i;
  // pin check off: pin counts as high
  assign ald_ok      = ald_s_i | ~ald_check_en_i;
  assign man_fall_o  = man_act_i & sync_prev_q & ~sync_s_i;
  assign auto_trig_o = auto_act_i & armed_i & lock_fall & ald_ok;
endmodule

// File: rtl/hold_fsm.sv
`timescale 1ns/1ps
module hold_fsm
  import hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_en_i,
  input  logic man_fall_i,
  input  logic auto_trig_i,
  input  logic sync_s_i,
  input  logic lock_det_i,
  input  logic ref_edge_i,
  output logic cp_hiz_o,
  output logic bcnt_rst_o,
  output logic armed_o
);
  hold_state_e state_q, state_d;
  logic man_pend_q, man_pend_d;
  logic auto_src_q, auto_src_d;
  logic bcnt_q, bcnt_d;
  logic man_block, release_ok;

  // manual cause persists until the synced pin is back high
  assign man_block  = (man_pend_q & ~sync_s_i) | man_fall_i;
  assign release_ok = ref_edge_i & ~man_block & ~auto_trig_i;

  always_comb begin
    state_d    = state_q;
    man_pend_d = man_pend_q;
    auto_src_d = auto_src_q;
    bcnt_d     = 1'b0;
    if (!hold_en_i) begin
      state_d    = ST_IDLE;
      man_pend_d = 1'b0;
      auto_src_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (man_fall_i || auto_trig_i) begin
            state_d    = ST_HIZ_WAIT_REF;
            man_pend_d = man_fall_i;
            auto_src_d = auto_trig_i;
          end
        end
        ST_HIZ_WAIT_REF: begin
          if (man_fall_i)  man_pend_d = 1'b1;
          if (auto_trig_i) auto_src_d = 1'b1;
          if (release_ok) begin
            state_d    = auto_src_q ? ST_WAIT_RELOCK : ST_IDLE;
            man_pend_d = 1'b0;
            bcnt_d     = 1'b1;
          end
        end
        ST_WAIT_RELOCK: begin
          if (man_fall_i) begin
            state_d    = ST_HIZ_WAIT_REF;
            man_pend_d = 1'b1;
          end else if (lock_det_i) begin
            state_d    = ST_IDLE;
            auto_src_d = 1'b0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      man_pend_q <= 1'b0;
      auto_src_q <= 1'b0;
      bcnt_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      man_pend_q <= man_pend_d;
      auto_src_q <= auto_src_d;
      bcnt_q     <= bcnt_d;
    end
  end

  assign cp_hiz_o   = (state_q == ST_HIZ_WAIT_REF);
  assign bcnt_rst_o = bcnt_q;
  assign armed_o    = (state_q != ST_WAIT_RELOCK);
endmodule

// File: rtl/cp_holdover_ctrl.sv
`timescale 1ns/1ps
module cp_holdover_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_ni,
  input  logic lock_det_i,
  input  logic ald_pin_i,
  input  logic ref_edge_i,
  input  logic master_en_i,
  input  logic func_en_i,
  input  logic manual_en_i,
  input  logic auto_en_i,
  input  logic ald_check_en_i,
  input  logic cal_req_i,
  output logic cp_hiz_o,
  output logic bcnt_rst_o,
  output logic cal_blocked_o
);
  logic hold_en, man_act, auto_act;
  logic sync_s, ald_s, man_fall, auto_trig, armed;

  assign hold_en       = master_en_i & func_en_i;
  assign man_act       = hold_en & manual_en_i;
  assign auto_act      = hold_en & auto_en_i;
  assign cal_blocked_o = cal_req_i & hold_en;

  hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_ni), .q_o(sync_s)
  );

  hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ald_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ald_pin_i), .q_o(ald_s)
  );

  hold_trig u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sync_s_i(sync_s), .lock_det_i(lock_det_i), .ald_s_i(ald_s),
    .ald_check_en_i(ald_check_en_i),
    .man_act_i(man_act), .auto_act_i(auto_act), .armed_i(armed),
    .man_fall_o(man_fall), .auto_trig_o(auto_trig)
  );

  hold_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_en_i(hold_en),
    .man_fall_i(man_fall), .auto_trig_i(auto_trig),
    .sync_s_i(sync_s), .lock_det_i(lock_det_i), .ref_edge_i(ref_edge_i),
    .cp_hiz_o(cp_hiz_o), .bcnt_rst_o(bcnt_rst_o), .armed_o(armed)
  );
endmodule

// File: rtl/hold_chk.sv
`timescale 1ns/1ps
module hold_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_en_i,
  input logic func_en_i,
  input logic ref_edge_i,
  input logic cp_hiz_o,
  input logic bcnt_rst_o
);
  // R5
  bcnt_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt_rst_o |=> !bcnt_rst_o);

  // R5
  bcnt_at_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt_rst_o |-> (!cp_hiz_o && $past(cp_hiz_o)));

  // R8
  hold_until_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_hiz_o && !ref_edge_i && master_en_i && func_en_i) |=> cp_hiz_o);

  // R2
  disabled_no_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(master_en_i && func_en_i) |=> !cp_hiz_o);

  // R12
  disable_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_hiz_o && !(master_en_i && func_en_i)) |=> !bcnt_rst_o);
endmodule

bind cp_holdover_ctrl hold_chk u_hold_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .master_en_i(master_en_i), .func_en_i(func_en_i),
  .ref_edge_i(ref_edge_i), .cp_hiz_o(cp_hiz_o), .bcnt_rst_o(bcnt_rst_o)
);

// File: tb/tb_cp_holdover_ctrl.sv
`timescale 1ns/1ps
module tb_cp_holdover_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_ni = 1'b1, lock_det = 1'b1, ald_pin = 1'b1, ref_edge = 1'b0;
  logic master_en = 1'b0, func_en = 1'b0, manual_en = 1'b0, auto_en = 1'b0;
  logic ald_chk = 1'b0, cal_req = 1'b0;
  logic cp_hiz, bcnt_rst, cal_blk;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cp_holdover_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_ni(sync_ni), .lock_det_i(lock_det),
    .ald_pin_i(ald_pin), .ref_edge_i(ref_edge), .master_en_i(master_en),
    .func_en_i(func_en), .manual_en_i(manual_en), .auto_en_i(auto_en),
    .ald_check_en_i(ald_chk), .cal_req_i(cal_req),
    .cp_hiz_o(cp_hiz), .bcnt_rst_o(bcnt_rst), .cal_blocked_o(cal_blk)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic m, logic f, logic mm, logic a, logic c);
    rst_ni = 1'b0;
    sync_ni = 1'b1; lock_det = 1'b1; ald_pin = 1'b1; ref_edge = 1'b0; cal_req = 1'b0;
    master_en = m; func_en = f; manual_en = mm; auto_en = a; ald_chk = c;
    cyc(2);
    rst_ni = 1'b1;
    cyc(3);
  endtask

  task automatic ref_pulse();
    ref_edge = 1'b1;
    cyc(1);
    ref_edge = 1'b0;
  endtask

  initial begin
    // R1
    do_reset(1, 1, 1, 1, 1);
    check("R1 hiz", cp_hiz, 1'b0);
    check("R1 bcnt", bcnt_rst, 1'b0);

    // R3 latency, R4 release boundary, R5 pulse
    do_reset(1, 1, 1, 0, 0);
    sync_ni = 1'b0;
    cyc(2); check("R3 before sync delay", cp_hiz, 1'b0);
    cyc(1); check("R3 entry", cp_hiz, 1'b1);
    ref_pulse();
    check("R4 ref ignored while low", cp_hiz, 1'b1);
    check("R5 no pulse", bcnt_rst, 1'b0);
    sync_ni = 1'b1;
    ref_pulse(); check("R4 ref edge 1", cp_hiz, 1'b1);
    ref_pulse(); check("R4 ref edge 2", cp_hiz, 1'b1);
    ref_pulse(); check("R4 ref edge 3 release", cp_hiz, 1'b0);
    check("R5 pulse at release", bcnt_rst, 1'b1);
    cyc(1); check("R5 pulse ends", bcnt_rst, 1'b0);

    // R12 disable in holdover, R3 edge not level
    do_reset(1, 1, 1, 0, 0);
    sync_ni = 1'b0; cyc(3);
    check("R3 entry", cp_hiz, 1'b1);
    master_en = 1'b0; cyc(1);
    check("R12 drop", cp_hiz, 1'b0);
    check("R12 no pulse", bcnt_rst, 1'b0);
    master_en = 1'b1; cyc(5);
    check("R3 level ignored", cp_hiz, 1'b0);
    sync_ni = 1'b1; cyc(3);
    sync_ni = 1'b0; cyc(3);
    check("R3 new fall", cp_hiz, 1'b1);

    // R6 R8 R9
    do_reset(1, 1, 0, 1, 1);
    lock_det = 1'b0; cyc(1);
    check("R6 auto entry", cp_hiz, 1'b1);
    ref_pulse();
    check("R8 release", cp_hiz, 1'b0);
    check("R5 pulse auto", bcnt_rst, 1'b1);
    for (int i = 0; i < 10; i++) begin
      ald_pin = ~ald_pin;
      ref_pulse();
      check("R9 no retrigger", cp_hiz, 1'b0);
    end
    ald_pin = 1'b1;
    lock_det = 1'b1; cyc(3);
    lock_det = 1'b0; cyc(1);
    check("R9 rearmed", cp_hiz, 1'b1);

    // R11 overlap
    do_reset(1, 1, 1, 1, 0);
    sync_ni = 1'b0; cyc(3);
    check("R11 manual entry", cp_hiz, 1'b1);
    lock_det = 1'b0; cyc(1);
    ref_pulse();
    check("R11 held by manual", cp_hiz, 1'b1);
    sync_ni = 1'b1; cyc(3);
    ref_pulse();
    check("R11 release", cp_hiz, 1'b0);
    check("R11 pulse", bcnt_rst, 1'b1);
    ref_pulse(); cyc(2);
    check("R11 R9 waits relock", cp_hiz, 1'b0);

    // R2 R13 sweep
    for (int k = 0; k < 16; k++) begin
      logic m, f, mm, a;
      m = k[3]; f = k[2]; mm = k[1]; a = k[0];
      do_reset(m, f, mm, a, 0);
      sync_ni = 1'b0; cyc(3);
      check("R2 R13 manual", cp_hiz, m & f & mm);
      sync_ni = 1'b1; cyc(3);
      ref_pulse(); cyc(1);
      check("R4 R13 clear", cp_hiz, 1'b0);
      lock_det = 1'b0; cyc(1);
      check("R2 R13 auto", cp_hiz, m & f & a);
    end

    // R7 sweep
    for (int k = 0; k < 4; k++) begin
      logic c, p;
      c = k[1]; p = k[0];
      do_reset(1, 1, 0, 1, c);
      ald_pin = p; cyc(3);
      lock_det = 1'b0; cyc(1);
      check("R7 pin qualify", cp_hiz, ~c | p);
    end

    // R10 sweep
    do_reset(0, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) begin
      master_en = k[2]; func_en = k[1]; cal_req = k[0];
      #1;
      check("R10 cal block", cal_blk, k[2] & k[1] & k[0]);
      cyc(1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule